// File: doc/BRIEF.md
# Frame Alignment Loss Monitor

This block sits behind the framing-pattern checker of a T1/E1 receive framer and decides when frame alignment should be treated as lost. The upstream framer does the frame search and bit extraction. For every framing bit it examines, it hands this block a strobe with a pass/fail flag. In E1 mode it also reports each FAS or NOT-FAS word it checks, with its result, and each CRC-4 check, with an error flag. The monitor applies the error criterion of the selected line format and raises an alarm when that criterion is met.

Superframe-style formats use a sliding history of recent framing-bit results with a population count. E1 uses two separate runs of consecutive bad words plus a count of CRC-4 errors over a fixed block of checks. All of these criteria feed one alarm.

The alarm appears three ways:
- a live level, which a "frame regained" pulse from the framer drops;
- a sticky status bit, which only a software clear-on-write strobe drops;
- a one-cycle event pulse when the live level rises.

A realign pulse, or any change of the format select, wipes all counting state.

Top module: `frame_loss_monitor`

## Requirements
- R1: Format code 0 (plain superframe): every bit strobe is counted. An erroneous bit strobe declares the alarm when the last 4 counted results (the last 6 when wideWin is 1), including itself, hold at least 2 errors.
- R2: Format code 1 (terminal-bit superframe): only bit strobes with bitPrimary=1 are counted, with a window of 4 and a threshold of 2 regardless of wideWin. Strobes with bitPrimary=0 have no effect.
- R3: Format code 2 (data superframe): every bit strobe is counted. An erroneous one declares the alarm when the last 12 results hold at least 4 errors.
- R4: Format code 3 (extended superframe): only bit strobes with bitPrimary=1 are counted. The window is 4, or 6 when wideWin is 1, and the threshold is 2.
- R5: Format code 4 (E1): a word strobe with wordIsFas=1 and wordErr=1 that is the third such in a row declares the alarm. A passing FAS word restarts that run. NOT-FAS words leave it untouched.
- R6: Format code 4: a word strobe with wordIsFas=0 and wordErr=1 that is the third such in a row declares the alarm. A passing NOT-FAS word restarts that run. FAS words leave it untouched.
- R7: Format code 4: an erroneous CRC-4 check declares the alarm when it is the 915th or later error within the current block of 1000 checks. Both counts clear after the 1000th check of each block.
- R8: Bit strobes have no effect in format code 4. Word and CRC-4 strobes have no effect in codes 0 to 3. All strobes have no effect in codes 5 to 7.
- R9: A realign pulse, or a cycle in which fmtSel differs from its value in the previous cycle, clears the history, both runs and both CRC-4 counts. Any strobe in that cycle is discarded.
- R10: lossLive is 1 from the clock edge that samples a declaring strobe. It stays 1 until a cycle with regained=1 and no declaration. A declaration in the same cycle as regained wins.
- R11: lossSticky sets together with lossLive and is cleared only by stickyClr. A declaration in the same cycle as stickyClr wins.
- R12: lossEvent is 1 for exactly the first cycle in which lossLive is 1 after being 0.
- R13: During and right after reset, all three outputs are 0 and the format history starts at code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fmtSel | input | 3 | Format code 0..4 (5..7 disable monitoring) |
| wideWin | input | 1 | Widens the short window to 6 in codes 0 and 3 |
| bitStb | input | 1 | One framing bit was examined |
| bitPrimary | input | 1 | The bit belongs to the checked subset (codes 1 and 3) |
| bitErr | input | 1 | The examined bit was wrong |
| wordStb | input | 1 | One E1 alignment word was examined |
| wordIsFas | input | 1 | 1 for a FAS word, 0 for a NOT-FAS word |
| wordErr | input | 1 | The examined word was wrong |
| crcChkStb | input | 1 | One CRC-4 check completed |
| crcErr | input | 1 | That CRC-4 check failed |
| realign | input | 1 | Clears all counting state |
| regained | input | 1 | Framer reports alignment recovered |
| stickyClr | input | 1 | Clear-on-write strobe for the sticky bit |
| lossLive | output | 1 | Live alarm level |
| lossSticky | output | 1 | Sticky alarm status |
| lossEvent | output | 1 | Pulse on the rising edge of lossLive |

## Verification
The bench first targets the window edges. An error that has just slid out of a 4-wide window must not count. With wideWin set, the same spacing must count. A design with the window one position off would trip early or stay quiet. For the E1 word runs, it interleaves the two word types and inserts single passing words. A design sharing one run counter, or failing to restart it, would declare on the wrong word.

The CRC-4 test sends exactly 914 errors in one block of 1000 checks and expects silence. It then sends 915 in the next block and expects the alarm on the 915th. An off-by-one threshold, or a block counter that never clears, shows there.

Same-cycle collisions are driven on purpose:
- a strobe together with a realign;
- a declaration together with regained;
- a declaration together with stickyClr.
A wrong priority leaves a flag in the wrong state. Long random runs with format switches, including unused codes, then compare every cycle against a model in the bench.

// File: rtl/frame_loss_pkg.sv
package frame_loss_pkg;

  typedef enum logic [2:0] {
    FMT_SF      = 3'd0,
    FMT_SF_TERM = 3'd1,
    FMT_SF_DATA = 3'd2,
    FMT_ESF     = 3'd3,
    FMT_E1      = 3'd4
  } fmt_e;

  typedef enum logic [1:0] {
    WIN_SHORT = 2'd0,
    WIN_MID   = 2'd1,
    WIN_LONG  = 2'd2
  } win_e;

  // Strobes and selects sent from control to the counting datapath
  typedef struct packed {
    logic clrAll;
    logic shiftEn;
    logic shiftVal;
    win_e winSel;
    logic fasEn;
    logic nfasEn;
    logic wordErr;
    logic crcEn;
    logic crcErr;
  } dp_cmd_t;

endpackage

// File: rtl/frame_loss_dp.sv
module frame_loss_dp
  import frame_loss_pkg::*;
#(
  parameter int HIST_DEPTH   = 12,
  parameter int SHORT_WIN    = 4,
  parameter int MID_WIN      = 6,
  parameter int CONSEC_LIMIT = 3,
  parameter int CRC_WINDOW   = 1000,
  localparam int CNT_W = $clog2(HIST_DEPTH + 1),
  localparam int RUN_W = $clog2(CONSEC_LIMIT + 1),
  localparam int CRC_W = $clog2(CRC_WINDOW + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dp_cmd_t          cmd,
  output logic [CNT_W-1:0] winErrs,
  output logic [RUN_W-1:0] fasRun,
  output logic [RUN_W-1:0] nfasRun,
  output logic [CRC_W-1:0] crcErrCnt
);

  logic [HIST_DEPTH-1:0] hist;
  logic [HIST_DEPTH-1:0] histShifted;
  logic [HIST_DEPTH-1:0] winMask;
  logic [HIST_DEPTH-1:0] histMasked;
  logic [CNT_W-1:0]      winLen;
  logic [CRC_W-1:0]      chkCnt;
  logic [CRC_W-1:0]      errCnt;
  logic [RUN_W-1:0]      runCnt [2];
  logic [1:0]            runEn;

  // History with the incoming result already shifted in
  assign histShifted = {hist[HIST_DEPTH-2:0], cmd.shiftVal};

  always_comb begin
    case (cmd.winSel)
      WIN_MID:  winLen = CNT_W'(MID_WIN);
      WIN_LONG: winLen = CNT_W'(HIST_DEPTH);
      default:  winLen = CNT_W'(SHORT_WIN);
    endcase
  end

  generate
    for (genvar g = 0; g < HIST_DEPTH; g++) begin : g_mask
      assign winMask[g] = (CNT_W'(g) < winLen);
    end
  endgenerate

  assign histMasked = histShifted & winMask;

  always_comb begin
    winErrs = '0;
    for (int i = 0; i < HIST_DEPTH; i++) begin
      winErrs = winErrs + CNT_W'(histMasked[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || cmd.clrAll) begin
      hist <= '0;
    end else if (cmd.shiftEn) begin
      hist <= histShifted;
    end
  end

  // Two identical saturating run counters: lane 0 FAS, lane 1 NOT-FAS
  assign runEn = {cmd.nfasEn, cmd.fasEn};

  generate
    for (genvar g = 0; g < 2; g++) begin : g_run
      always_ff @(posedge clk) begin
        if (!rstN || cmd.clrAll) begin
          runCnt[g] <= '0;
        end else if (runEn[g]) begin
          if (!cmd.wordErr) begin
            runCnt[g] <= '0;
          end else if (runCnt[g] < RUN_W'(CONSEC_LIMIT)) begin
            runCnt[g] <= runCnt[g] + 1'b1;
          end
        end
      end
    end
  endgenerate

  assign fasRun  = runCnt[0];
  assign nfasRun = runCnt[1];

  // CRC-4 block counters
  always_ff @(posedge clk) begin
    if (!rstN || cmd.clrAll) begin
      chkCnt <= '0;
      errCnt <= '0;
    end else if (cmd.crcEn) begin
      if (chkCnt == CRC_W'(CRC_WINDOW - 1)) begin
        chkCnt <= '0;
        errCnt <= '0;
      end else begin
        chkCnt <= chkCnt + 1'b1;
        errCnt <= errCnt + CRC_W'(cmd.crcErr);
      end
    end
  end

  assign crcErrCnt = errCnt;

  // R8
  family_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cmd.shiftEn && (cmd.fasEn || cmd.nfasEn || cmd.crcEn)));

  // R7
  crc_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    chkCnt < CRC_W'(CRC_WINDOW));

  // R9
  clr_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clrAll |=> (hist == '0 && chkCnt == '0 && errCnt == '0));

  // R5
  fas_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.fasEn && !cmd.wordErr && !cmd.clrAll) |=> (runCnt[0] == '0));

  // R6
  nfas_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.fasEn && !cmd.nfasEn && !cmd.clrAll) |=> $stable(runCnt[1]));

endmodule

// File: rtl/frame_loss_ctrl.sv
module frame_loss_ctrl
  import frame_loss_pkg::*;
#(
  parameter int HIST_DEPTH   = 12,
  parameter int SHORT_THRESH = 2,
  parameter int LONG_THRESH  = 4,
  parameter int CONSEC_LIMIT = 3,
  parameter int CRC_WINDOW   = 1000,
  parameter int CRC_LIMIT    = 914,
  localparam int CNT_W = $clog2(HIST_DEPTH + 1),
  localparam int RUN_W = $clog2(CONSEC_LIMIT + 1),
  localparam int CRC_W = $clog2(CRC_WINDOW + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       fmtSel,
  input  logic             wideWin,
  input  logic             bitStb,
  input  logic             bitPrimary,
  input  logic             bitErr,
  input  logic             wordStb,
  input  logic             wordIsFas,
  input  logic             wordErr,
  input  logic             crcChkStb,
  input  logic             crcErr,
  input  logic             realign,
  input  logic             regained,
  input  logic             stickyClr,
  input  logic [CNT_W-1:0] winErrs,
  input  logic [RUN_W-1:0] fasRun,
  input  logic [RUN_W-1:0] nfasRun,
  input  logic [CRC_W-1:0] crcErrCnt,
  output dp_cmd_t          cmd,
  output logic             lossLive,
  output logic             lossSticky,
  output logic             lossEvent
);

  logic [2:0]       fmtPrev;
  logic             fmtChange;
  logic             clrReq;
  logic [CNT_W-1:0] winThresh;
  logic             winTrip;
  logic             fasTrip;
  logic             nfasTrip;
  logic             crcTrip;
  logic             tripAny;

  always_ff @(posedge clk) begin
    if (!rstN) fmtPrev <= 3'd0;
    else       fmtPrev <= fmtSel;
  end

  assign fmtChange = (fmtSel != fmtPrev);
  assign clrReq    = realign | fmtChange;

  // Mode decode: which strobes reach the datapath, and with what window
  always_comb begin
    cmd          = '0;
    cmd.clrAll   = clrReq;
    cmd.shiftVal = bitErr;
    cmd.wordErr  = wordErr;
    cmd.crcErr   = crcErr;
    cmd.winSel   = WIN_SHORT;
    winThresh    = CNT_W'(SHORT_THRESH);
    case (fmt_e'(fmtSel))
      FMT_SF: begin
        cmd.shiftEn = bitStb;
        cmd.winSel  = wideWin ? WIN_MID : WIN_SHORT;
      end
      FMT_SF_TERM: begin
        cmd.shiftEn = bitStb & bitPrimary;
      end
      FMT_SF_DATA: begin
        cmd.shiftEn = bitStb;
        cmd.winSel  = WIN_LONG;
        winThresh   = CNT_W'(LONG_THRESH);
      end
      FMT_ESF: begin
        cmd.shiftEn = bitStb & bitPrimary;
        cmd.winSel  = wideWin ? WIN_MID : WIN_SHORT;
      end
      FMT_E1: begin
        cmd.fasEn  = wordStb & wordIsFas;
        cmd.nfasEn = wordStb & ~wordIsFas;
        cmd.crcEn  = crcChkStb;
      end
      default: ;
    endcase
    if (clrReq) begin
      cmd.shiftEn = 1'b0;
      cmd.fasEn   = 1'b0;
      cmd.nfasEn  = 1'b0;
      cmd.crcEn   = 1'b0;
    end
  end

  // Declaration happens only on the strobe that completes a criterion
  assign winTrip  = cmd.shiftEn & bitErr & (winErrs >= winThresh);
  assign fasTrip  = cmd.fasEn & wordErr & (fasRun >= RUN_W'(CONSEC_LIMIT - 1));
  assign nfasTrip = cmd.nfasEn & wordErr & (nfasRun >= RUN_W'(CONSEC_LIMIT - 1));
  assign crcTrip  = cmd.crcEn & crcErr & (crcErrCnt >= CRC_W'(CRC_LIMIT));
  assign tripAny  = winTrip | fasTrip | nfasTrip | crcTrip;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lossLive   <= 1'b0;
      lossSticky <= 1'b0;
      lossEvent  <= 1'b0;
    end else begin
      lossLive   <= tripAny | (lossLive & ~regained);
      lossSticky <= tripAny | (lossSticky & ~stickyClr);
      lossEvent  <= tripAny & ~lossLive;
    end
  end

  // R10
  live_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lossLive) |-> $past(regained));

  // R11
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lossSticky) |-> $past(stickyClr));

  // R12
  event_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    lossEvent |=> !lossEvent);

  // R12
  event_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    lossEvent |-> (lossLive && lossSticky));

  // R11
  sticky_cover_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lossLive) |-> lossSticky);

endmodule

// File: rtl/frame_loss_monitor.sv
module frame_loss_monitor
  import frame_loss_pkg::*;
#(
  parameter int HIST_DEPTH   = 12,
  parameter int SHORT_WIN    = 4,
  parameter int MID_WIN      = 6,
  parameter int SHORT_THRESH = 2,
  parameter int LONG_THRESH  = 4,
  parameter int CONSEC_LIMIT = 3,
  parameter int CRC_WINDOW   = 1000,
  parameter int CRC_LIMIT    = 914
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] fmtSel,
  input  logic       wideWin,
  input  logic       bitStb,
  input  logic       bitPrimary,
  input  logic       bitErr,
  input  logic       wordStb,
  input  logic       wordIsFas,
  input  logic       wordErr,
  input  logic       crcChkStb,
  input  logic       crcErr,
  input  logic       realign,
  input  logic       regained,
  input  logic       stickyClr,
  output logic       lossLive,
  output logic       lossSticky,
  output logic       lossEvent
);

  localparam int CNT_W = $clog2(HIST_DEPTH + 1);
  localparam int RUN_W = $clog2(CONSEC_LIMIT + 1);
  localparam int CRC_W = $clog2(CRC_WINDOW + 1);

  dp_cmd_t          cmd;
  logic [CNT_W-1:0] winErrs;
  logic [RUN_W-1:0] fasRun;
  logic [RUN_W-1:0] nfasRun;
  logic [CRC_W-1:0] crcErrCnt;

  frame_loss_ctrl #(
    .HIST_DEPTH  (HIST_DEPTH),
    .SHORT_THRESH(SHORT_THRESH),
    .LONG_THRESH (LONG_THRESH),
    .CONSEC_LIMIT(CONSEC_LIMIT),
    .CRC_WINDOW  (CRC_WINDOW),
    .CRC_LIMIT   (CRC_LIMIT)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .fmtSel    (fmtSel),
    .wideWin   (wideWin),
    .bitStb    (bitStb),
    .bitPrimary(bitPrimary),
    .bitErr    (bitErr),
    .wordStb   (wordStb),
    .wordIsFas (wordIsFas),
    .wordErr   (wordErr),
    .crcChkStb (crcChkStb),
    .crcErr    (crcErr),
    .realign   (realign),
    .regained  (regained),
    .stickyClr (stickyClr),
    .winErrs   (winErrs),
    .fasRun    (fasRun),
    .nfasRun   (nfasRun),
    .crcErrCnt (crcErrCnt),
    .cmd       (cmd),
    .lossLive  (lossLive),
    .lossSticky(lossSticky),
    .lossEvent (lossEvent)
  );

  frame_loss_dp #(
    .HIST_DEPTH  (HIST_DEPTH),
    .SHORT_WIN   (SHORT_WIN),
    .MID_WIN     (MID_WIN),
    .CONSEC_LIMIT(CONSEC_LIMIT),
    .CRC_WINDOW  (CRC_WINDOW)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .winErrs  (winErrs),
    .fasRun   (fasRun),
    .nfasRun  (nfasRun),
    .crcErrCnt(crcErrCnt)
  );

endmodule

// File: tb/frame_loss_monitor_test.sv
module frame_loss_monitor_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] fmtSel = 3'd0;
  logic wideWin = 1'b0;
  logic bitStb = 1'b0, bitPrimary = 1'b0, bitErr = 1'b0;
  logic wordStb = 1'b0, wordIsFas = 1'b0, wordErr = 1'b0;
  logic crcChkStb = 1'b0, crcErr = 1'b0;
  logic realign = 1'b0, regained = 1'b0, stickyClr = 1'b0;
  logic lossLive, lossSticky, lossEvent;

  int checks = 0;
  int errors = 0;

  // Reference model state
  bit [11:0] mHist = '0;
  int mFas = 0, mNfas = 0, mCrcE = 0, mCrcC = 0;
  logic [2:0] mFmtPrev = 3'd0;
  bit expLive = 0, expSticky = 0, expEvent = 0;

  always #4 clk = ~clk;  // 125 MHz

  frame_loss_monitor uut (
    .clk(clk), .rstN(rstN), .fmtSel(fmtSel), .wideWin(wideWin),
    .bitStb(bitStb), .bitPrimary(bitPrimary), .bitErr(bitErr),
    .wordStb(wordStb), .wordIsFas(wordIsFas), .wordErr(wordErr),
    .crcChkStb(crcChkStb), .crcErr(crcErr), .realign(realign),
    .regained(regained), .stickyClr(stickyClr),
    .lossLive(lossLive), .lossSticky(lossSticky), .lossEvent(lossEvent)
  );

  function automatic int ones(bit [11:0] h, int len);
    int n = 0;
    for (int i = 0; i < len; i++) n += h[i];
    return n;
  endfunction

  // Next expected outputs from the requirements, given the inputs now driven
  function automatic void modelStep();
    bit trip = 0;
    int len, thr;
    bit counted;
    if (realign || fmtSel != mFmtPrev) begin
      mHist = '0; mFas = 0; mNfas = 0; mCrcE = 0; mCrcC = 0;
    end else if (fmtSel <= 3'd3) begin
      counted = (fmtSel == 3'd1 || fmtSel == 3'd3) ? (bitStb && bitPrimary) : bitStb;
      len = (fmtSel == 3'd2) ? 12 : (((fmtSel == 3'd0 || fmtSel == 3'd3) && wideWin) ? 6 : 4);
      thr = (fmtSel == 3'd2) ? 4 : 2;
      if (counted) begin
        mHist = {mHist[10:0], bitErr};
        if (bitErr && ones(mHist, len) >= thr) trip = 1;
      end
    end else if (fmtSel == 3'd4) begin
      if (wordStb && wordIsFas) begin
        if (wordErr) begin
          if (mFas >= 2) trip = 1;
          if (mFas < 3) mFas++;
        end else mFas = 0;
      end
      if (wordStb && !wordIsFas) begin
        if (wordErr) begin
          if (mNfas >= 2) trip = 1;
          if (mNfas < 3) mNfas++;
        end else mNfas = 0;
      end
      if (crcChkStb) begin
        mCrcC++;
        if (crcErr) begin
          mCrcE++;
          if (mCrcE > 914) trip = 1;
        end
        if (mCrcC == 1000) begin mCrcC = 0; mCrcE = 0; end
      end
    end
    mFmtPrev = fmtSel;
    expEvent  = trip && !expLive;
    expLive   = trip || (expLive && !regained);
    expSticky = trip || (expSticky && !stickyClr);
  endfunction

  task automatic check(string tag);
    checks++;
    if (lossLive !== expLive || lossSticky !== expSticky || lossEvent !== expEvent) begin
      errors++;
      $display("FAIL %s: live/sticky/event actual %b%b%b expected %b%b%b",
               tag, lossLive, lossSticky, lossEvent, expLive, expSticky, expEvent);
    end
  endtask

  task automatic tick(string tag);
    modelStep();
    @(posedge clk);
    @(negedge clk);
    check(tag);
    bitStb = 0; bitPrimary = 0; bitErr = 0;
    wordStb = 0; wordIsFas = 0; wordErr = 0;
    crcChkStb = 0; crcErr = 0;
    realign = 0; regained = 0; stickyClr = 0;
  endtask

  task automatic bitS(bit err, bit prim, string tag);
    bitStb = 1; bitErr = err; bitPrimary = prim;
    tick(tag);
  endtask

  task automatic wordS(bit isFas, bit err, string tag);
    wordStb = 1; wordIsFas = isFas; wordErr = err;
    tick(tag);
  endtask

  task automatic crcS(bit err, string tag);
    crcChkStb = 1; crcErr = err;
    tick(tag);
  endtask

  task automatic setFmt(logic [2:0] f, string tag);
    fmtSel = f;
    tick(tag);
  endtask

  task automatic expectLive(bit v, string tag);
    checks++;
    if (lossLive !== v) begin
      errors++;
      $display("FAIL %s: lossLive actual %b expected %b", tag, lossLive, v);
    end
  endtask

  function automatic string tagFor(logic [2:0] f);
    case (f)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      default: return "R8";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run still active, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seedVal;
    seedVal = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    check("R13 in reset");
    rstN = 1;
    tick("R13 after reset");

    // R1: 2 of 4 and the 6-wide variant
    bitS(1, 0, "R1"); bitS(0, 0, "R1"); bitS(0, 0, "R1"); bitS(1, 0, "R1");
    expectLive(1, "R1 two of four");
    regained = 1; tick("R10 regained");
    expectLive(0, "R10 dropped");
    realign = 1; tick("R9");
    bitS(1, 0, "R1"); bitS(0, 0, "R1"); bitS(0, 0, "R1"); bitS(0, 0, "R1"); bitS(1, 0, "R1");
    expectLive(0, "R1 error slid out of 4");
    wideWin = 1; realign = 1; tick("R9");
    bitS(1, 0, "R1"); bitS(0, 0, "R1"); bitS(0, 0, "R1"); bitS(0, 0, "R1"); bitS(1, 0, "R1");
    expectLive(1, "R1 wide window");
    stickyClr = 1; regained = 1; tick("R11 clear");

    // R2: non-primary bits ignored, wideWin ignored
    setFmt(3'd1, "R9 fmt change");
    for (int i = 0; i < 5; i++) bitS(1, 0, "R2 ignored");
    expectLive(0, "R2 non-primary ignored");
    bitS(1, 1, "R2"); bitS(0, 1, "R2"); bitS(0, 1, "R2"); bitS(0, 1, "R2"); bitS(1, 1, "R2");
    expectLive(0, "R2 window stays 4");
    bitS(1, 1, "R2");
    expectLive(1, "R2 declare");
    regained = 1; stickyClr = 1; tick("R10");

    // R3: 4 of 12
    setFmt(3'd2, "R9 fmt change");
    for (int i = 0; i < 3; i++) begin bitS(1, 0, "R3"); bitS(0, 0, "R3"); end
    expectLive(0, "R3 three errors");
    bitS(1, 0, "R3");
    expectLive(1, "R3 fourth error");
    regained = 1; realign = 1; tick("R9");
    bitS(1, 0, "R3");
    for (int i = 0; i < 11; i++) bitS(0, 0, "R3");
    bitS(1, 0, "R3"); bitS(1, 0, "R3"); bitS(1, 0, "R3");
    expectLive(0, "R3 oldest slid out");
    bitS(1, 0, "R3");
    expectLive(1, "R3 declare");
    regained = 1; tick("R10");

    // R4: extended superframe
    setFmt(3'd3, "R9 fmt change");
    bitS(1, 0, "R4 ignored"); bitS(1, 0, "R4 ignored");
    expectLive(0, "R4 non-primary ignored");
    bitS(1, 1, "R4"); bitS(0, 1, "R4"); bitS(0, 1, "R4"); bitS(0, 1, "R4"); bitS(0, 1, "R4"); bitS(1, 1, "R4");
    expectLive(1, "R4 wide window edge");
    regained = 1; stickyClr = 1; tick("R11");
    wideWin = 0;

    // R8: word and CRC strobes ignored in superframe modes
    for (int i = 0; i < 4; i++) wordS(1, 1, "R8 word in SF");
    for (int i = 0; i < 4; i++) crcS(1, "R8 crc in SF");
    expectLive(0, "R8 SF ignores E1 strobes");

    // R5 / R6: separate consecutive runs
    setFmt(3'd4, "R9 fmt change");
    for (int i = 0; i < 6; i++) bitS(1, 1, "R8 bit in E1");
    expectLive(0, "R8 E1 ignores bits");
    wordS(1, 1, "R5"); wordS(0, 1, "R6"); wordS(1, 1, "R5"); wordS(1, 0, "R5 restart");
    wordS(1, 1, "R5"); wordS(0, 1, "R6"); wordS(1, 1, "R5");
    expectLive(0, "R5 run restarted");
    wordS(0, 0, "R6 restart");
    wordS(1, 1, "R5");
    expectLive(1, "R5 third FAS error");
    regained = 1; realign = 1; tick("R9");
    wordS(0, 1, "R6"); wordS(1, 1, "R6 interleave"); wordS(0, 1, "R6");
    expectLive(0, "R6 two so far");
    wordS(0, 1, "R6");
    expectLive(1, "R6 third NOT-FAS error");
    regained = 1; realign = 1; tick("R9");

    // R7: CRC-4 block threshold
    for (int i = 0; i < 914; i++) crcS(1, "R7 below limit");
    for (int i = 0; i < 86; i++) crcS(0, "R7 below limit");
    expectLive(0, "R7 914 errors no alarm");
    for (int i = 0; i < 914; i++) crcS(1, "R7");
    expectLive(0, "R7 before 915th");
    crcS(1, "R7");
    expectLive(1, "R7 915th error");
    regained = 1; stickyClr = 1; realign = 1; tick("R9");

    // R9: strobe together with realign is discarded; format bounce clears
    setFmt(3'd0, "R9 fmt change");
    bitS(1, 0, "R9");
    realign = 1; bitS(1, 0, "R9 strobe with realign");
    bitS(1, 0, "R9");
    expectLive(0, "R9 realign cleared history");
    setFmt(3'd3, "R9 bounce"); setFmt(3'd0, "R9 bounce");
    bitS(1, 0, "R9");
    expectLive(0, "R9 format change cleared");

    // R10 / R11 collisions
    regained = 1; stickyClr = 1; bitS(1, 0, "R10 trip with regained");
    expectLive(1, "R10 trip wins");
    stickyClr = 1; tick("R11 clear alone");
    regained = 1; tick("R10 regained alone");
    realign = 1; tick("R9");

    // Random mix
    for (int n = 0; n < 20000; n++) begin
      if ($urandom % 400 == 0) fmtSel = 3'($urandom % 8);
      if ($urandom % 200 == 0) wideWin = 1'($urandom);
      bitStb = 1'($urandom % 3 == 0); bitPrimary = 1'($urandom); bitErr = 1'($urandom % 4 == 0);
      wordStb = 1'($urandom % 3 == 0); wordIsFas = 1'($urandom); wordErr = 1'($urandom % 3 == 0);
      crcChkStb = 1'($urandom % 2); crcErr = 1'($urandom % 2);
      realign = 1'($urandom % 300 == 0);
      regained = 1'($urandom % 40 == 0);
      stickyClr = 1'($urandom % 50 == 0);
      tick(tagFor(fmtSel));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule